// File: doc/BRIEF.md
# Parallel Arithmetic/Logic Unit

This block is a 32-bit ALU in which a carry-select adder and a separate bitwise logic unit compute side by side from the same pair of latched operands. A result multiplexer picks one of the two outputs. Before either operand reaches the adder or the logic unit, it may be inverted bit by bit through a row of XOR gates. Each operand has its own invert control. With the external carry-in, this gives addition, A minus B (A + ~B + 1) and B minus A (~A + B + 1) from the same adder. One zero detector sits on the multiplexer output. N is taken from the sign bit of the selected result. C and V come from the adder.

Operations arrive on a valid/ready stream and results leave on another. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. It is first captured in the operand latch. On the next edge that the output stage can take it, the operation moves into the output register, and it is presented there until `out_ready` is high. `in_ready` depends combinationally on `out_ready`. With the output stalled, the block holds two operations, and then it lowers `in_ready`.

Top module: `alu_par_core`

## Requirements
- R1: `in_ready` is low only while both the operand latch and the output register are full and `out_ready` is low. An operation is taken in only on an edge where `in_valid` and `in_ready` are both high.
- R2: In arithmetic mode (`sel_logic`=0), `result` equals A' + B' + `carry_in` modulo 2^32. Here A' is `opa` XORed with 32 copies of `inv_a`, and B' is `opb` XORed with 32 copies of `inv_b`.
- R3: In arithmetic mode, `flag_c` is the carry out of bit 31 of A' + B' + `carry_in`. For subtraction (A + ~B + 1), C=1 means no borrow.
- R4: In arithmetic mode, `flag_v` is 1 exactly when A' and B' have the same bit 31 and the sum's bit 31 differs from it. For example, 0x7FFFFFFF + 1 gives V=1.
- R5: In logic mode (`sel_logic`=1), `result` is computed from A' and B' by `logic_fn`: 2'b00 gives AND, 2'b01 gives OR, 2'b10 gives XOR, 2'b11 passes B'.
- R6: A logic-mode operation leaves `flag_c` and `flag_v` at the values left by the most recent arithmetic operation, or at 0 if none has run since reset.
- R7: `flag_z` is 1 exactly when the presented 32-bit `result` is zero. `flag_n` equals bit 31 of `result`. Both hold in either mode.
- R8: After reset, `out_valid` is 0, `in_ready` is 1 and all four flags are 0.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `result` and the flags do not change.
- R10: Each accepted operation produces exactly one output, and outputs appear in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can take an operation this edge |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| inv_a | input | 1 | Invert operand A before use |
| inv_b | input | 1 | Invert operand B before use |
| carry_in | input | 1 | Carry into the adder's bit 0 |
| sel_logic | input | 1 | 1 selects the logic unit, 0 selects the adder |
| logic_fn | input | 2 | Logic function code (see R5) |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the presented result this edge |
| result | output | 32 | Selected result |
| flag_n | output | 1 | Negative: bit 31 of result |
| flag_z | output | 1 | Zero: result is all zeros |
| flag_c | output | 1 | Adder carry out, held across logic operations |
| flag_v | output | 1 | Adder signed overflow, held across logic operations |

## Verification
The handshake assertions assume that the consumer obeys the stream rules. In particular, `out_ready` may be low for any number of cycles, but the presented word is then expected to stay put. The adder check assumes that the latched operands are never unknown, which the reset of the operand latch guarantees. The bench drives every input on the falling edge and holds the fields steady until `in_ready` has been seen high at a falling edge. It raises `out_ready` only when it means to consume a result. This keeps every offered operation within those assumptions.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    LF_AND   = 2'b00,
    LF_OR    = 2'b01,
    LF_XOR   = 2'b10,
    LF_PASSB = 2'b11
  } logic_fn_e;

  typedef struct packed {
    logic      inv_a;
    logic      inv_b;
    logic      cin;
    logic      sel_logic;
    logic_fn_e fn;
  } op_ctl_t;

endpackage

// File: rtl/alu_opnd_stage.sv
module alu_opnd_stage
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  op_ctl_t          ctl_in,
  output logic [WIDTH-1:0] a_x,
  output logic [WIDTH-1:0] b_x,
  output op_ctl_t          ctl_q
);

  logic [WIDTH-1:0] a_q, b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      ctl_q <= '0;
    end else if (load) begin
      a_q   <= a_in;
      b_q   <= b_in;
      ctl_q <= ctl_in;
    end
  end

  // XOR rows: conditional one's complement of each operand
  assign a_x = a_q ^ {WIDTH{ctl_q.inv_a}};
  assign b_x = b_q ^ {WIDTH{ctl_q.inv_b}};

endmodule

// File: rtl/alu_csel_adder.sv
module alu_csel_adder #(
  parameter int WIDTH = 32,
  parameter int BLK_W = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NBLK = WIDTH / BLK_W;

  logic [BLK_W:0] bsum0 [NBLK];
  logic [BLK_W:0] bsum1 [NBLK];

  // Each block precomputes its sum for both possible incoming carries
  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    logic [BLK_W-1:0] xa, xb;
    assign xa       = a[g*BLK_W +: BLK_W];
    assign xb       = b[g*BLK_W +: BLK_W];
    assign bsum0[g] = {1'b0, xa} + {1'b0, xb};
    assign bsum1[g] = {1'b0, xa} + {1'b0, xb} + {{BLK_W{1'b0}}, 1'b1};
  end

  // Carry selects the precomputed block result
  always_comb begin
    logic           c;
    logic [BLK_W:0] pick;
    c   = cin;
    sum = '0;
    for (int i = 0; i < NBLK; i++) begin
      pick                   = c ? bsum1[i] : bsum0[i];
      sum[i*BLK_W +: BLK_W]  = pick[BLK_W-1:0];
      c                      = pick[BLK_W];
    end
    cout = c;
  end

  // R2 R3: selected blocks agree with a full-width sum
  always_comb begin
    a_r2_r3_adder_sum: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("carry-select sum mismatch");
  end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic_fn_e        fn,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    unique case (fn)
      LF_AND:   y = a & b;
      LF_OR:    y = a | b;
      LF_XOR:   y = a ^ b;
      LF_PASSB: y = b;
      default:  y = b;
    endcase
  end

  // R5: AND result never has a bit that OR lacks
  always_comb begin
    a_r5_and_within_or: assert (!(fn == LF_AND) || ((y & ~(a | b)) == '0))
      else $error("logic unit AND produced bit outside OR");
  end

endmodule

// File: rtl/alu_par_core.sv
module alu_par_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             inv_a,
  input  logic             inv_b,
  input  logic             carry_in,
  input  logic             sel_logic,
  input  logic [1:0]       logic_fn,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);

  localparam int MSB = WIDTH - 1;

  // ---------------- stream control ----------------
  logic s1_valid;
  logic s1_adv;
  logic in_take;

  assign s1_adv   = s1_valid && (!out_valid || out_ready);
  assign in_ready = !s1_valid || s1_adv;
  assign in_take  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (in_take)       s1_valid <= 1'b1;
      else if (s1_adv)   s1_valid <= 1'b0;
      if (s1_adv)        out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  // ---------------- operand latch and inversion ----------------
  op_ctl_t          ctl_in, ctl_q;
  logic [WIDTH-1:0] a_x, b_x;

  assign ctl_in = '{inv_a: inv_a, inv_b: inv_b, cin: carry_in,
                    sel_logic: sel_logic, fn: logic_fn_e'(logic_fn)};

  alu_opnd_stage #(.WIDTH(WIDTH)) u_opnd (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (in_take),
    .a_in   (opa),
    .b_in   (opb),
    .ctl_in (ctl_in),
    .a_x    (a_x),
    .b_x    (b_x),
    .ctl_q  (ctl_q)
  );

  // ---------------- parallel datapaths ----------------
  logic [WIDTH-1:0] add_y, lgc_y, mux_y;
  logic             add_c, add_v;

  alu_csel_adder #(.WIDTH(WIDTH), .BLK_W(BLK_W)) u_add (
    .a    (a_x),
    .b    (b_x),
    .cin  (ctl_q.cin),
    .sum  (add_y),
    .cout (add_c)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_lgc (
    .a  (a_x),
    .b  (b_x),
    .fn (ctl_q.fn),
    .y  (lgc_y)
  );

  assign add_v = (a_x[MSB] == b_x[MSB]) && (add_y[MSB] != a_x[MSB]);
  assign mux_y = ctl_q.sel_logic ? lgc_y : add_y;

  // ---------------- output register and flags ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end else if (s1_adv) begin
      result <= mux_y;
      flag_n <= mux_y[MSB];
      flag_z <= (mux_y == '0);
      if (!ctl_q.sel_logic) begin
        flag_c <= add_c;
        flag_v <= add_v;
      end
    end
  end

  // ---------------- assertions ----------------
  a_r1_ready_low_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (s1_valid && out_valid && !out_ready));

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(flag_n)
                                  && $stable(flag_z) && $stable(flag_c) && $stable(flag_v)));

  a_r6_cv_kept_on_logic: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_adv && ctl_q.sel_logic) |=> ($stable(flag_c) && $stable(flag_v)));

  a_r7_zero_matches_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((flag_z == (result == '0)) && (flag_n == result[MSB])));

  a_r4_overflow_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_adv && !ctl_q.sel_logic && (a_x[MSB] != b_x[MSB])) |=> !flag_v);

endmodule

// File: tb/alu_par_core_tb.sv
module alu_par_core_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [31:0] opa, opb;
  logic        inv_a, inv_b, carry_in, sel_logic;
  logic [1:0]  logic_fn;
  logic        out_valid, out_ready;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;

  int n_checks = 0;
  int n_errors = 0;

  // model flag state
  logic m_c = 1'b0;
  logic m_v = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  alu_par_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opa(opa), .opb(opb), .inv_a(inv_a), .inv_b(inv_b), .carry_in(carry_in),
    .sel_logic(sel_logic), .logic_fn(logic_fn), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model of one operation; updates held C/V
  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic ia,
                       input logic ib, input logic ci, input logic sl, input logic [1:0] fn,
                       output logic [31:0] y, output logic [3:0] nzcv);
    logic [31:0] ax, bx;
    logic [32:0] s;
    ax = ia ? ~a : a;
    bx = ib ? ~b : b;
    if (!sl) begin
      s   = {1'b0, ax} + {1'b0, bx} + {32'd0, ci};
      y   = s[31:0];
      m_c = s[32];
      m_v = (ax[31] == bx[31]) && (s[31] != ax[31]);
    end else begin
      case (fn)
        2'b00:   y = ax & bx;
        2'b01:   y = ax | bx;
        2'b10:   y = ax ^ bx;
        default: y = bx;
      endcase
    end
    nzcv = {y[31], (y == 32'd0), m_c, m_v};
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic ia,
                       input logic ib, input logic ci, input logic sl, input logic [1:0] fn);
    opa = a; opb = b; inv_a = ia; inv_b = ib; carry_in = ci; sel_logic = sl; logic_fn = fn;
    in_valid = 1'b1;
  endtask

  // one full operation with out_ready high, then check
  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic ia, input logic ib, input logic ci, input logic sl,
                        input logic [1:0] fn);
    logic [31:0] ey;
    logic [3:0]  ef;
    model(a, b, ia, ib, ci, sl, fn, ey, ef);
    @(negedge clk);
    drive(a, b, ia, ib, ci, sl, fn);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    check({req, " result"}, result, ey);
    check({req, " NZCV"}, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, ef});
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R8 out_valid", {31'd0, out_valid}, 32'd0);
    check("R8 in_ready", {31'd0, in_ready}, 32'd1);
    check("R8 flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
  endtask

  task automatic t_add();
    run_op("R2 add small", 32'd5, 32'd7, 0, 0, 0, 0, 2'b00);
    run_op("R2 add cin", 32'h1234_5678, 32'h0FED_CBA8, 0, 0, 1, 0, 2'b00);
    run_op("R3 R7 wrap to zero", 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, 2'b00);
    run_op("R4 overflow 7FFFFFFF+1", 32'h7FFF_FFFF, 32'd1, 0, 0, 0, 0, 2'b00);
    run_op("R4 neg overflow", 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 2'b00);
    run_op("R4 mixed sign no V", 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 1, 0, 2'b00);
  endtask

  task automatic t_sub();
    run_op("R2 R3 A-B no borrow", 32'd10, 32'd3, 0, 1, 1, 0, 2'b00);
    run_op("R2 R3 A-B borrow", 32'd3, 32'd10, 0, 1, 1, 0, 2'b00);
    run_op("R7 A-B equal zero", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 1, 1, 0, 2'b00);
    run_op("R2 B-A reverse", 32'd3, 32'd10, 1, 0, 1, 0, 2'b00);
    run_op("R4 sub overflow", 32'h8000_0000, 32'd1, 0, 1, 1, 0, 2'b00);
  endtask

  task automatic t_logic();
    // set C=1 V=1 first, so the hold of R6 is visible
    run_op("R4 set CV", 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 2'b00);
    for (int f = 0; f < 4; f++) begin
      for (int inv = 0; inv < 4; inv++) begin
        run_op("R5 R6 logic", 32'hF0F0_A5A5, 32'hFF00_3C3C, inv[1], inv[0], 1,
               1, f[1:0]);
      end
    end
    run_op("R7 logic zero", 32'h0000_00F0, 32'h0000_000F, 0, 0, 0, 1, 2'b00);
  endtask

  task automatic t_backpressure();
    logic [31:0] y1, y2;
    logic [3:0]  f1, f2;
    model(32'd100, 32'd1, 0, 0, 0, 0, 2'b00, y1, f1);
    model(32'hAAAA_0000, 32'h5555_0000, 0, 0, 0, 1, 2'b01, y2, f2);
    @(negedge clk);
    out_ready = 1'b0;
    drive(32'd100, 32'd1, 0, 0, 0, 0, 2'b00);
    @(negedge clk);
    drive(32'hAAAA_0000, 32'h5555_0000, 0, 0, 0, 1, 2'b01);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 ready low when full", {31'd0, in_ready}, 32'd0);
    check("R10 first out", result, y1);
    repeat (3) @(negedge clk);
    check("R9 stall valid", {31'd0, out_valid}, 32'd1);
    check("R9 stall result", result, y1);
    check("R9 stall flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, f1});
    out_ready = 1'b1;
    @(negedge clk);
    check("R10 second out valid", {31'd0, out_valid}, 32'd1);
    check("R10 second out", result, y2);
    check("R10 second flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, f2});
    @(negedge clk);
    check("R10 no extra output", {31'd0, out_valid}, 32'd0);
    check("R1 ready after drain", {31'd0, in_ready}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    opa = '0; opb = '0; inv_a = 0; inv_b = 0; carry_in = 0; sel_logic = 0; logic_fn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule